// File: doc/BRIEF.md
# Drive-Bay Indicator Serial Link Driver

This block keeps the activity, locate and fault indicator state for a set of drive bays and sends it to an external LED controller over three wires: a serial clock, a load strobe and a data line. The state lives in a pattern register that holds three bits for each bay slot. A static port-to-slot table decides which slot, and so which three bits, each port owns.

When a port posts an update message, the block decodes three indicator flags from the message, writes them into that port's bits, and sends a full frame. A frame begins with a programmable number of padding pulses. One pulse with the load strobe high follows. Then the block shifts out three data bits for each live port, lowest pattern bit first, one bit per clock pulse. A programmable number of trailing padding pulses ends the frame. Each clock pulse is high for a parameterised number of system cycles and then low for the same number. An update that arrives while a frame is in progress changes the register at once and causes exactly one further frame after the current one. Several such updates are merged into that single frame.

Top module: `bay_led_serializer`

## Requirements
- R1: Out of reset, `sclk`, `sload` and `sdata` are all high and `busy` is low.
- R2: Port p owns pattern bits 3*s, 3*s+1 and 3*s+2, where s is the 3-bit field at `slot_map[3p+2:3p]`. Offset 0 holds activity, offset 1 holds locate and offset 2 holds fault.
- R3: An accepted message sets the activity bit when `upd_msg[21:20]` is non-zero, sets the locate bit when `upd_msg[19]` is 1, and sets the fault bit when `upd_msg[22]` is 1. Each of these bits is cleared otherwise. The bits of other ports do not change.
- R4: A message with `upd_msg[15:8]` greater than or equal to MAX_SLOTS (15) is rejected. It leaves the pattern unchanged and produces no clock pulse.
- R5: A frame consists of `cfg_pre` pulses with `sload` low, then one pulse with `sload` high, then 3*`cfg_ports` data pulses, then `cfg_post` pulses. Every pulse other than the load pulse has `sload` low.
- R6: Data pulse i carries pattern bit i on `sdata`, lowest bit first. On every non-data pulse `sdata` is high. `sdata` and `sload` stay stable while `sclk` is high.
- R7: Within a frame, every `sclk` pulse is high for exactly HALF_CYCLES cycles and then low for exactly HALF_CYCLES cycles.
- R8: When `cfg_pre` is 0 the load pulse is the first pulse of the frame. When `cfg_post` is 0 the frame ends after the last data pulse.
- R9: Updates accepted during a frame lead to exactly one further frame. That frame starts directly after the current one and carries the pattern as it stands when the new frame starts.
- R10: After a frame ends and `busy` falls, `sclk` and `sload` are low and `sdata` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | One-cycle update request |
| upd_port | input | PORT_W | Port the update applies to |
| upd_msg | input | 32 | Update message carrying the slot field and the indicator flags |
| slot_map | input | NUM_PORTS*SLOT_W | Slot index for each port, one field per port |
| cfg_pre | input | PAD_W | Number of leading padding pulses |
| cfg_post | input | PAD_W | Number of trailing padding pulses |
| cfg_ports | input | NP_W | Number of ports shifted per frame |
| sclk | output | 1 | Serial clock to the LED controller |
| sload | output | 1 | Load strobe |
| sdata | output | 1 | Serial data |
| busy | output | 1 | High while a frame is being sent |

## Verification
The assertions assume the following about the inputs: the slot table is a permutation with every entry below NUM_PORTS, `cfg_ports` is between 1 and NUM_PORTS, and the configuration inputs do not change while a frame is in progress. The stimulus uses one fixed reversed slot table. It changes `cfg_pre`, `cfg_post` and `cfg_ports` only while `busy` is low, and only after the previous frame has fully drained. Rejected messages are sent only while the link is idle, so the absence of pulses can be seen at the pins.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_LOAD,
        ST_DATA,
        ST_POST
    } bls_state_e;

    // Message field positions: the slot field and the three indicator flags
    localparam int MSG_SLOT_LO = 8;
    localparam int MSG_ACT_LO  = 20;
    localparam int MSG_ACT_HI  = 21;
    localparam int MSG_LOC     = 19;
    localparam int MSG_FLT     = 22;

endpackage

// File: rtl/bls_pattern.sv
module bls_pattern #(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3,
    parameter int SLOT_W    = 3,
    parameter int MAX_SLOTS = 15,
    localparam int PW       = 3 * NUM_PORTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_valid,
    input  logic [PORT_W-1:0]           upd_port,
    input  logic [31:0]                 upd_msg,
    input  logic [NUM_PORTS*SLOT_W-1:0] slot_map,
    output logic [PW-1:0]               pattern_q,
    output logic                        changed_q
);
    import bls_pkg::*;

    typedef struct packed {
        logic [PW-1:0] pat;
        logic          chg;
    } pat_state_t;

    pat_state_t s_d, s_q;

    logic              accept;
    logic [SLOT_W-1:0] slot;
    int unsigned       base;

    always_comb begin
        s_d     = s_q;
        s_d.chg = 1'b0;
        accept  = upd_valid && (upd_msg[MSG_SLOT_LO +: 8] < 8'(MAX_SLOTS));
        slot    = slot_map[int'(upd_port) * SLOT_W +: SLOT_W];
        base    = 3 * int'(slot);
        if (accept && (base + 2 < PW)) begin
            s_d.pat[base]     = |upd_msg[MSG_ACT_HI:MSG_ACT_LO];
            s_d.pat[base + 1] = upd_msg[MSG_LOC];
            s_d.pat[base + 2] = upd_msg[MSG_FLT];
            s_d.chg           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pattern_q = s_q.pat;
    assign changed_q = s_q.chg;

endmodule

// File: rtl/bls_frame_fsm.sv
module bls_frame_fsm #(
    parameter int NUM_PORTS = 8,
    parameter int HALF      = 12500,
    parameter int PAD_W     = 4,
    localparam int PW       = 3 * NUM_PORTS,
    localparam int NP_W     = $clog2(NUM_PORTS + 1),
    localparam int TW       = $clog2(2 * HALF),
    localparam int CNT_W    = $clog2(PW + (1 << PAD_W) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic [PW-1:0]    pattern,
    input  logic [PAD_W-1:0] cfg_pre,
    input  logic [PAD_W-1:0] cfg_post,
    input  logic [NP_W-1:0]  cfg_ports,
    output logic             sclk,
    output logic             sload,
    output logic             sdata,
    output logic             busy
);
    import bls_pkg::*;

    typedef struct packed {
        bls_state_e       st;
        logic [TW-1:0]    tmr;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    shreg;
        logic [PAD_W-1:0] post;
        logic [CNT_W-1:0] nbits;
        logic             pend;
        logic             ran;
    } fsm_state_t;

    fsm_state_t s_d, s_q;

    logic last_tick;
    logic go;
    logic fin;

    always_comb begin
        s_d       = s_q;
        go        = 1'b0;
        fin       = 1'b0;
        last_tick = (s_q.tmr == TW'(2 * HALF - 1));

        if (s_q.st != ST_IDLE) begin
            s_d.tmr = last_tick ? '0 : s_q.tmr + 1'b1;
            if (kick) s_d.pend = 1'b1;
        end

        case (s_q.st)
            ST_IDLE: go = kick || s_q.pend;
            ST_PRE: if (last_tick) begin
                if (s_q.cnt == '0) s_d.st = ST_LOAD;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_LOAD: if (last_tick) begin
                s_d.st  = ST_DATA;
                s_d.cnt = s_q.nbits - 1'b1;
            end
            ST_DATA: if (last_tick) begin
                s_d.shreg = s_q.shreg >> 1;
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.post == '0) begin
                    fin = 1'b1;
                end else begin
                    s_d.st  = ST_POST;
                    s_d.cnt = CNT_W'(s_q.post) - 1'b1;
                end
            end
            ST_POST: if (last_tick) begin
                if (s_q.cnt == '0) fin = 1'b1;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (fin) begin
            s_d.ran = 1'b1;
            if (s_q.pend || kick) go = 1'b1;
            else                  s_d.st = ST_IDLE;
        end

        if (go) begin
            s_d.shreg = pattern;
            s_d.post  = cfg_post;
            s_d.nbits = CNT_W'(cfg_ports) * CNT_W'(3);
            s_d.pend  = 1'b0;
            s_d.tmr   = '0;
            if (cfg_pre == '0) begin
                s_d.st = ST_LOAD;
            end else begin
                s_d.st  = ST_PRE;
                s_d.cnt = CNT_W'(cfg_pre) - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = (s_q.st != ST_IDLE);
    assign sclk  = busy ? (s_q.tmr < TW'(HALF)) : !s_q.ran;
    assign sload = busy ? (s_q.st == ST_LOAD) : !s_q.ran;
    assign sdata = (s_q.st == ST_DATA) ? s_q.shreg[0] : 1'b1;

endmodule

// File: rtl/bay_led_serializer.sv
module bay_led_serializer #(
    parameter int NUM_PORTS   = 8,
    parameter int MAX_SLOTS   = 15,
    parameter int HALF_CYCLES = 12500,
    parameter int PAD_W       = 4,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int SLOT_W     = PORT_W,
    localparam int PW         = 3 * NUM_PORTS,
    localparam int NP_W       = $clog2(NUM_PORTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_valid,
    input  logic [PORT_W-1:0]           upd_port,
    input  logic [31:0]                 upd_msg,
    input  logic [NUM_PORTS*SLOT_W-1:0] slot_map,
    input  logic [PAD_W-1:0]            cfg_pre,
    input  logic [PAD_W-1:0]            cfg_post,
    input  logic [NP_W-1:0]             cfg_ports,
    output logic                        sclk,
    output logic                        sload,
    output logic                        sdata,
    output logic                        busy
);

    logic [PW-1:0] pattern_q;
    logic          changed_q;

    bls_pattern #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .SLOT_W    (SLOT_W),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_pattern (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_port  (upd_port),
        .upd_msg   (upd_msg),
        .slot_map  (slot_map),
        .pattern_q (pattern_q),
        .changed_q (changed_q)
    );

    bls_frame_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .HALF      (HALF_CYCLES),
        .PAD_W     (PAD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (changed_q),
        .pattern   (pattern_q),
        .cfg_pre   (cfg_pre),
        .cfg_post  (cfg_post),
        .cfg_ports (cfg_ports),
        .sclk      (sclk),
        .sload     (sload),
        .sdata     (sdata),
        .busy      (busy)
    );

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
    parameter int HALF      = 12500,
    parameter int MAX_SLOTS = 15,
    parameter int PW        = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_valid,
    input logic [31:0]   upd_msg,
    input logic [PW-1:0] pattern,
    input logic          sclk,
    input logic          sload,
    input logic          sdata,
    input logic          busy
);
    logic [31:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= (busy && sclk)  ? hi_q + 1 : '0;
            lo_q <= (busy && !sclk) ? lo_q + 1 : '0;
        end
    end

    // R7: the high phase never runs longer than HALF cycles
    a_r7_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sclk |-> hi_q < 32'(HALF));

    // R7: the low phase never runs longer than HALF cycles
    a_r7_low_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sclk |-> lo_q < 32'(HALF));

    // R6: data and load stay stable while the clock is high
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && sclk && $past(sclk) |-> $stable(sdata) && $stable(sload));

    // R10: line levels after a frame
    a_r10_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sclk && !sload && sdata);

    // R4: a rejected message leaves the pattern alone
    a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && (upd_msg[15:8] >= 8'(MAX_SLOTS)) |=> $stable(pattern));

endmodule

bind bay_led_serializer bls_checker #(
    .HALF      (HALF_CYCLES),
    .MAX_SLOTS (MAX_SLOTS),
    .PW        (PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_msg   (upd_msg),
    .pattern   (pattern_q),
    .sclk      (sclk),
    .sload     (sload),
    .sdata     (sdata),
    .busy      (busy)
);

// File: tb/bay_led_serializer_test.sv
module bay_led_serializer_test;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_port = '0;
    logic [31:0] upd_msg = '0;
    logic [23:0] slot_map;
    logic [3:0]  cfg_pre = '0;
    logic [3:0]  cfg_post = '0;
    logic [3:0]  cfg_ports = 4'd8;
    logic        sclk, sload, sdata, busy;

    always #2 clk = ~clk;

    bay_led_serializer #(.HALF_CYCLES(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_port(upd_port),
        .upd_msg(upd_msg), .slot_map(slot_map), .cfg_pre(cfg_pre),
        .cfg_post(cfg_post), .cfg_ports(cfg_ports), .sclk(sclk),
        .sload(sload), .sdata(sdata), .busy(busy)
    );

    typedef struct {
        int          pre;
        int          post;
        int          n;
        logic [23:0] pat;
        string       tag;
    } frame_t;

    frame_t      exp_q[$];
    logic [23:0] model = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          fall_cnt = 0;
    bit          done = 0;

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Driver: one-cycle update, with the bench's own model of the pattern
    task automatic update(int port, int slotf, logic [1:0] act, bit loc, bit flt);
        logic [31:0] m;
        int base;
        m = '0;
        m[15:8] = 8'(slotf);
        m[21:20] = act;
        m[19] = loc;
        m[22] = flt;
        @(negedge clk);
        upd_valid = 1'b1;
        upd_port = 3'(port);
        upd_msg = m;
        @(negedge clk);
        upd_valid = 1'b0;
        upd_msg = '0;
        if (slotf < 15) begin
            base = 3 * (7 - port);
            model[base]     = |act;
            model[base + 1] = loc;
            model[base + 2] = flt;
        end
    endtask

    task automatic expect_frame(string tag);
        frame_t f;
        f.pre = int'(cfg_pre);
        f.post = int'(cfg_post);
        f.n = int'(cfg_ports);
        f.pat = model;
        f.tag = tag;
        exp_q.push_back(f);
    endtask

    task automatic wait_idle(string tag);
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, {"R9 all frames seen ", tag}, exp_q.size(), 0);
        check(!sclk && !sload && sdata && !busy, {"R10 idle lines ", tag},
              {sclk, sload, sdata, busy}, 4'b0010);
    endtask

    // Monitor: collects pulses at each clock fall and compares whole frames
    bit   prev_sclk;
    bit   rose;
    int   hi_run;
    int   pn;
    logic [63:0] loads, datas;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 1; rose = 0; hi_run = 0; pn = 0; loads = '0; datas = '0;
        end else begin
            if (sclk && !prev_sclk) begin
                rose = 1;
                hi_run = 1;
            end else if (sclk) begin
                hi_run++;
            end
            if (!sclk && prev_sclk) begin
                fall_cnt++;
                if (rose) check(hi_run == HALF, "R7 high time", hi_run, HALF);
                rose = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected pulse", pn, 0);
                end else begin
                    frame_t f;
                    int total;
                    logic [63:0] el, ed;
                    f = exp_q[0];
                    loads[pn] = sload;
                    datas[pn] = sdata;
                    pn++;
                    total = f.pre + 1 + 3 * f.n + f.post;
                    if (pn == total) begin
                        el = '0;
                        ed = '0;
                        for (int i = 0; i < total; i++) begin
                            el[i] = (i == f.pre);
                            if (i > f.pre && i <= f.pre + 3 * f.n) ed[i] = f.pat[i - f.pre - 1];
                            else ed[i] = 1'b1;
                        end
                        check(loads == el, {"R5 R8 layout ", f.tag}, loads, el);
                        check(datas == ed, {"R6 R2 R3 data ", f.tag}, datas, ed);
                        void'(exp_q.pop_front());
                        pn = 0;
                        loads = '0;
                        datas = '0;
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int fc;
        bit saw_busy;
        for (int p = 0; p < 8; p++) slot_map[p*3 +: 3] = 3'(7 - p);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk && sload && sdata && !busy, "R1 reset levels",
              {sclk, sload, sdata, busy}, 4'b1110);

        // R8: no padding; R2/R3 activity from bit 20
        update(0, 0, 2'b01, 0, 0);
        expect_frame("nopad act");
        wait_idle("nopad");

        // R5: padding on both sides; all flags on port 3, activity from bit 21
        cfg_pre = 4'd2;
        cfg_post = 4'd3;
        update(3, 1, 2'b10, 1, 1);
        expect_frame("pad all");
        wait_idle("pad all");

        // R3: the same port, locate and fault cleared
        update(3, 2, 2'b01, 0, 0);
        expect_frame("clear");
        wait_idle("clear");

        // R4: a slot field of 15 is rejected; no pulses
        fc = fall_cnt;
        saw_busy = 0;
        update(5, 15, 2'b11, 1, 1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy) saw_busy = 1;
        end
        check(fall_cnt == fc && !saw_busy, "R4 reject no pulses", fall_cnt - fc, 0);
        update(5, 0, 2'b00, 1, 0);
        expect_frame("after reject");
        wait_idle("after reject");

        // R5: two live ports only (slots 0 and 1 = ports 7 and 6)
        cfg_ports = 4'd2;
        cfg_pre = 4'd0;
        cfg_post = 4'd1;
        update(7, 3, 2'b00, 0, 1);
        expect_frame("two ports");
        wait_idle("two ports");

        // R9: updates during a frame merge into one follow-up frame
        cfg_ports = 4'd8;
        cfg_pre = 4'd1;
        cfg_post = 4'd1;
        update(1, 0, 2'b01, 0, 0);
        expect_frame("first");
        repeat (20) @(negedge clk);
        check(busy, "R9 busy during frame", busy, 1);
        update(2, 0, 2'b00, 0, 1);
        update(4, 0, 2'b00, 1, 0);
        expect_frame("merged");
        wait_idle("merged");

        finish_run();
    end

endmodule